// File: doc/BRIEF.md
# Lockable Watchdog Timer with Feed Sequence

This block is a watchdog counter for a single-clock system. A clock enable, `wd_tick`, is derived elsewhere from whichever watchdog clock source is selected. Each tick advances a two-bit prescaler, and every fourth tick decrements a 24-bit counter. Software keeps the system alive by reloading the counter in time. A reload needs two writes to the feed register in a row: 0xAA, then 0x55. If the counter reaches the end of its period, the block acts. It also acts at once when the feed sequence is wrong or broken off. The action is a one-cycle reset request when reset mode is selected, and an interrupt request otherwise.

Software can turn the enable on but cannot turn it off. Only the hardware reset `rst_n` or a watchdog event clears the enable. Counting starts only after the first correct feed that follows enabling, so the counter always starts from a known value. A sticky flag records that a watchdog event took place. It survives the reset the block requests and is cleared only by software writing zero to it. A debug-halt input freezes the prescaler and the counter.

The register port is a simple one-cycle bus. Address 0 is the mode register: bit 0 is enable, bit 1 is reset mode, bit 2 is the flag. Address 1 is the reload constant. Address 2 is the feed register, which reads as zero. Address 3 is the current count, which is read-only.

Top module: `wdt_lockable`

## Requirements
- R1: A write of 0xAA to address 2 (low byte compared), followed by a write of 0x55 to address 2 as the very next bus access, loads the counter with the reload constant and clears the prescaler. The count reads back at address 3.
- R2: A write to address 1 stores the reload constant, except that a value below 0xFF is stored as 0xFF. The reload constant reads back at address 1 and resets to 0xFF.
- R3: Writing 1 to mode bit 0 sets the enable, and writing 0 to it has no effect. The enable is cleared only by `rst_n` or by a watchdog event. Mode bit 1 (reset mode) is freely writable.
- R4: The counter moves only when the block is enabled and a correct feed has occurred since enabling. It decrements once every 4 ticks. An expiry occurs on tick number (constant+1)×4 counted from a correct feed. The count resets to 0xFF.
- R5: With reset mode set, a watchdog event raises `wdt_reset_req` for exactly one cycle, in the cycle after the event. It also sets the flag.
- R6: The flag (mode bit 2, output `wdt_flag`) is set by every watchdog event. Writing mode bit 2 as 0 clears it; writing it as 1 leaves it unchanged. `wdt_irq` is high while the flag is set and reset mode is off.
- R7: While `dbg_halt` is high, the prescaler and the counter do not change.
- R8: While the block is counting, an incomplete or wrong feed causes a watchdog event at once. This covers any bus access other than the 0x55 feed write after 0xAA, and any feed write other than 0xAA that does not complete a sequence.
- R9: A wrong feed while the block is not counting causes no event and leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wd_tick | input | 1 | One-cycle enable derived from the selected watchdog clock |
| dbg_halt | input | 1 | Debug halt; freezes counting |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for `bus_addr` |
| wdt_reset_req | output | 1 | One-cycle system reset request |
| wdt_irq | output | 1 | Interrupt request |
| wdt_flag | output | 1 | Sticky watchdog-event flag |

## Verification
The bench first checks that enabling without a feed leaves the count frozen. A design that started counting early would run from a stale value. It then measures the exact tick count to expiry at the minimum reload constant and at a larger one. An off-by-one in the prescaler or the zero test would show up as a shifted period. Further checks interrupt a feed with a plain read, try to clear the enable by writing zero, and clear the flag with both bit values. A long random stretch of bus traffic is compared cycle by cycle against a behavioural model. It catches priority errors, such as a feed arriving on the expiry tick or a flag clear arriving in the same cycle as an event.

// File: rtl/wdt_lockable.sv
module wdt_lockable #(
  parameter int          CNT_W  = 24,
  parameter int          PRE_W  = 2,
  parameter int          TC_MIN = 255,
  parameter logic [7:0]  KEY_A  = 8'hAA,
  parameter logic [7:0]  KEY_B  = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_tick,
  input  logic             dbg_halt,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             wdt_reset_req,
  output logic             wdt_irq,
  output logic             wdt_flag
);

  localparam logic [1:0]       A_MODE = 2'd0;
  localparam logic [1:0]       A_TC   = 2'd1;
  localparam logic [1:0]       A_FEED = 2'd2;
  localparam logic [1:0]       A_CNT  = 2'd3;
  localparam logic [CNT_W-1:0] FLOOR  = CNT_W'(TC_MIN);

  logic             en_q, rmode_q, flag_q, armed_q, run_q, rreq_q;
  logic [CNT_W-1:0] tc_q, cnt_q;
  logic [PRE_W-1:0] pre_q;

  wire access  = bus_wr | bus_rd;
  wire feed_wr = bus_wr && (bus_addr == A_FEED);
  wire mode_wr = bus_wr && (bus_addr == A_MODE);
  wire tc_wr   = bus_wr && (bus_addr == A_TC);
  wire key_a   = bus_wdata[7:0] == KEY_A;
  wire key_b   = bus_wdata[7:0] == KEY_B;

  wire good    = armed_q && feed_wr && key_b;
  wire bad     = armed_q ? (access && !good) : (feed_wr && !key_a);
  wire active  = en_q && run_q;
  wire step    = active && wd_tick && !dbg_halt;
  wire expire  = step && (&pre_q) && (cnt_q == '0) && !good;
  wire wd_evt  = active && (bad || expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      armed_q <= !access;
    end else begin
      armed_q <= feed_wr && key_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= FLOOR;
    end else if (tc_wr) begin
      tc_q <= (bus_wdata < FLOOR) ? FLOOR : bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= FLOOR;
      pre_q <= '0;
    end else if (good) begin
      cnt_q <= tc_q;
      pre_q <= '0;
    end else if (step) begin
      pre_q <= pre_q + 1'b1;
      if ((&pre_q) && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rmode_q <= 1'b0;
      flag_q  <= 1'b0;
      run_q   <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      rreq_q <= wd_evt && rmode_q;
      if (mode_wr) rmode_q <= bus_wdata[1];
      if (wd_evt) begin
        en_q   <= 1'b0;
        run_q  <= 1'b0;
        flag_q <= 1'b1;
      end else begin
        if (mode_wr && bus_wdata[0]) en_q <= 1'b1;
        if (mode_wr && !bus_wdata[2]) flag_q <= 1'b0;
        if (good && en_q) run_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = CNT_W'({flag_q, rmode_q, en_q});
      A_TC:    bus_rdata = tc_q;
      A_CNT:   bus_rdata = cnt_q;
      default: bus_rdata = '0;
    endcase
  end

  assign wdt_reset_req = rreq_q;
  assign wdt_flag      = flag_q;
  assign wdt_irq       = flag_q && !rmode_q;

  AST_TC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q >= FLOOR); // R2
  AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> flag_q); // R3
  AST_IDLE_UNTIL_FED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !feed_wr) |=> $stable(cnt_q)); // R4
  AST_RREQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |-> flag_q); // R5
  AST_RREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> !rreq_q); // R5
  AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |-> flag_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(mode_wr && !bus_wdata[2])); // R6
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !access) |=> ($stable(cnt_q) && $stable(pre_q))); // R7

endmodule

// File: tb/tb_wdt_lockable.sv
module tb_wdt_lockable;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wd_tick = 1'b0, dbg_halt = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [23:0] bus_wdata = '0, bus_rdata;
  logic wdt_reset_req, wdt_irq, wdt_flag;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdt_lockable dut (.clk, .rst_n, .wd_tick, .dbg_halt, .bus_wr, .bus_rd, .bus_addr,
                    .bus_wdata, .bus_rdata, .wdt_reset_req, .wdt_irq, .wdt_flag);

  int m_en, m_rm, m_flag, m_arm, m_run, m_rreq, m_tc, m_cnt, m_pre;

  always @(posedge clk) begin
    bit acc, fw, good, bad, act, stp, expd, ev;
    if (!rst_n) begin
      m_en = 0; m_rm = 0; m_flag = 0; m_arm = 0; m_run = 0; m_rreq = 0;
      m_tc = 255; m_cnt = 255; m_pre = 0;
    end else begin
      acc = bus_wr || bus_rd;
      fw = bus_wr && bus_addr == 2;
      good = 0; bad = 0;
      if (m_arm != 0 && acc) begin
        good = fw && bus_wdata[7:0] == 8'h55;
        bad = !good;
        m_arm = 0;
      end else if (m_arm == 0 && fw) begin
        if (bus_wdata[7:0] == 8'hAA) m_arm = 1; else bad = 1;
      end
      act = m_en != 0 && m_run != 0;
      stp = act && wd_tick && !dbg_halt;
      expd = stp && m_pre == 3 && m_cnt == 0 && !good;
      ev = act && (bad || expd);
      m_rreq = (ev && m_rm != 0) ? 1 : 0;
      if (good) begin
        m_cnt = m_tc; m_pre = 0;
        if (m_en != 0) m_run = 1;
      end else if (stp) begin
        if (m_pre == 3) begin
          m_pre = 0;
          if (m_cnt > 0) m_cnt = m_cnt - 1;
        end else m_pre = m_pre + 1;
      end
      if (bus_wr && bus_addr == 0) begin
        if (bus_wdata[0]) m_en = 1;
        m_rm = bus_wdata[1];
        if (!bus_wdata[2]) m_flag = 0;
      end
      if (bus_wr && bus_addr == 1) m_tc = (bus_wdata < 255) ? 255 : int'(bus_wdata);
      if (ev) begin m_en = 0; m_run = 0; m_flag = 1; end
    end
  end

  function automatic int mexp(logic [1:0] a);
    case (a)
      2'd0: return m_flag * 4 + m_rm * 2 + m_en;
      2'd1: return m_tc;
      2'd3: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 reset_req vs model", int'(wdt_reset_req), m_rreq);
    chk("R6 irq vs model", int'(wdt_irq), (m_flag != 0 && m_rm == 0) ? 1 : 0);
    chk("R6 flag vs model", int'(wdt_flag), m_flag);
  end

  task automatic wr(logic [1:0] a, int d);
    bus_wr = 1; bus_addr = a; bus_wdata = 24'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    bus_rd = 1; bus_addr = a;
    #1;
    v = int'(bus_rdata);
    case (a)
      2'd0: chk("R3 mode read vs model", v, mexp(a));
      2'd1: chk("R2 tc read vs model", v, mexp(a));
      2'd3: chk("R4 count read vs model", v, mexp(a));
      default: chk("R1 feed read vs model", v, mexp(a));
    endcase
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic feed();
    wr(2, 'hAA);
    wr(2, 'h55);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R5 reset_req after reset", int'(wdt_reset_req), 0);
    chk("R6 irq after reset", int'(wdt_irq), 0);
    rd(0, v); chk("R3 mode after reset", v, 0);
    rd(1, v); chk("R2 tc after reset", v, 'hFF);
    rd(3, v); chk("R4 count after reset", v, 'hFF);

    wr(1, 'h10);  rd(1, v); chk("R2 small tc floored", v, 'hFF);
    wr(1, 'h300); rd(1, v); chk("R2 tc stored", v, 'h300);
    wr(1, 'h100);

    wr(0, 1);
    wd_tick = 1; repeat (50) @(negedge clk); wd_tick = 0;
    rd(3, v); chk("R4 no counting before feed", v, 'hFF);
    wr(0, 0); rd(0, v); chk("R3 enable not clearable", v, 1);

    feed();
    rd(3, v); chk("R1 feed reloads count", v, 'h100);
    wd_tick = 1; repeat (20) @(negedge clk); wd_tick = 0;
    rd(3, v); chk("R4 count after 20 ticks", v, 'hFB);
    dbg_halt = 1; wd_tick = 1; repeat (30) @(negedge clk); wd_tick = 0; dbg_halt = 0;
    rd(3, v); chk("R7 halt freezes count", v, 'hFB);

    feed();
    n = 0; wd_tick = 1;
    do begin @(posedge clk); n++; @(negedge clk); end while (!wdt_flag && n < 5000);
    wd_tick = 0;
    chk("R4 ticks to expiry tc=0x100", n, 1028);
    chk("R6 irq on expiry", int'(wdt_irq), 1);
    rd(0, v); chk("R3 enable cleared by event", v, 4);

    wr(0, 4); rd(0, v); chk("R6 writing flag 1 keeps it", v, 4);
    wr(0, 0); rd(0, v); chk("R6 flag cleared by zero", v, 0);
    chk("R6 irq drops", int'(wdt_irq), 0);

    wr(0, 3); feed();
    wr(2, 'hAA);
    rd(3, v);
    chk("R8 interrupted feed raises reset_req", int'(wdt_reset_req), 1);
    chk("R5 flag with reset_req", int'(wdt_flag), 1);
    @(negedge clk);
    chk("R5 reset_req one cycle", int'(wdt_reset_req), 0);
    rd(0, v); chk("R3 mode after reset event", v, 6);

    wr(0, 2);
    wr(2, 'h55);
    @(negedge clk);
    chk("R9 idle bad feed no flag", int'(wdt_flag), 0);
    chk("R9 idle bad feed no reset_req", int'(wdt_reset_req), 0);

    wr(1, 0); wr(0, 3); feed();
    n = 0; wd_tick = 1;
    do begin @(posedge clk); n++; @(negedge clk); end while (!wdt_reset_req && n < 5000);
    wd_tick = 0;
    chk("R5 ticks to reset at minimum tc", n, 1024);

    for (int i = 0; i < 6000; i++) begin
      int k;
      wd_tick = ($urandom % 3) != 0;
      dbg_halt = ($urandom % 8) == 0;
      k = $urandom % 24;
      if (k < 4) wr(2, 'hAA);
      else if (k < 8) wr(2, 'h55);
      else if (k == 8) wr(2, $urandom % 256);
      else if (k == 9) wr(0, $urandom % 8);
      else if (k == 10) wr(0, 3);
      else if (k == 11) wr(1, $urandom % 'h180);
      else if (k < 14) rd(2'($urandom % 4), v);
      else @(negedge clk);
    end
    wd_tick = 0; dbg_halt = 0;
    @(negedge clk);
    finish_run();
  end
endmodule